// File: doc/BRIEF.md
# H-Bridge Control and Fault Logic

This block is the digital control core of a full H-bridge built from two half-bridge legs. It takes a sleep/enable input, a pair of disable inputs of opposite polarity (one active-high, one active-low), one polarity input per leg and three protection flags: supply undervoltage, overtemperature and hard short. From these it decides, every clock, whether each leg's high-side or low-side switch may conduct. It also drives an active-low fault status output.

All control and flag inputs are brought into the clock domain through synchronizer chains before they are decoded. A supervisory controller decides whether the bridge drives, brakes, floats or sleeps. It holds overtemperature and short faults in a latch, which only a disable toggle or a reset clears. An undervoltage fault needs no latch, because it lifts as soon as the flag drops. A per-leg datapath turns each leg request into gate enables. It inserts a configurable dead time between one switch of a leg turning off and the other turning on.

A system controller uses it by holding enable high and both disables inactive, then steering the two polarity inputs for forward, reverse or braking. To recover from a latched fault, it pulses either disable input.

Top module: `hbridge_ctrl`

## Requirements
- R1: While normal drive is allowed, a leg whose polarity input is 1 ends with only its high-side enable asserted. A leg whose polarity input is 0 ends with only its low-side enable asserted. Polarity bit 0 steers leg 0 and bit 1 steers leg 1.
- R2: Polarity inputs 2'b11 settle to both high sides on. Polarity inputs 2'b00 settle to both low sides on, which is braking.
- R3: When enable is high and either disHiIn=1 or disLoNIn=0, all four gate enables are 0 and faultN is 0.
- R4: When enable is low, all four gate enables are 0 and faultN is 1, whatever the other inputs are.
- R5: An undervoltage flag with enable high forces all gates off and faultN to 0. Once the flag drops, faultN returns to 1 and the legs follow the present inputs again, with no other action needed.
- R6: An overtemperature or short flag seen while enable is high latches the fault. All gates then stay off and faultN stays 0 after the flag drops, and a sleep period does not release the latch.
- R7: The latched fault clears only after either disable input enters its disabling state, or on reset. Once the disable is released, drive resumes.
- R8: The high-side and low-side enables of one leg are never both 1. When a leg switches sides, both of its enables stay 0 for max(deadTime,1) cycles.
- R9: A change on a control input reaches the gate enables and faultN at the third rising clock edge after it is applied, when no dead-time wait applies.
- R10: After reset, all gate enables are 0, faultN is 1 and no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| deadTime | input | DEAD_W | Dead-time length in cycles; quasi-static configuration |
| enIn | input | 1 | Enable; low selects sleep |
| disHiIn | input | 1 | Active-high disable |
| disLoNIn | input | 1 | Active-low disable |
| polIn | input | 2 | Per-leg polarity; bit i steers leg i |
| uvFlag | input | 1 | Undervoltage flag (self-clearing fault) |
| otFlag | input | 1 | Overtemperature flag (latched fault) |
| shortFlag | input | 1 | Hard-short flag (latched fault) |
| gateHi | output | 2 | High-side enables, bit i for leg i |
| gateLo | output | 2 | Low-side enables, bit i for leg i |
| faultN | output | 1 | Active-low fault status |

## Verification
The bench builds the block with DEAD_W=3 and SYNC_DEPTH=2. With DEAD_W=3 the largest dead time, 7, can be reached in a handful of cycles, so a side change after the counter has saturated is exercised alongside a deadTime of 0, which still yields the one-cycle minimum gap. The two-stage synchronizer fixes the three-edge latency the reference model predicts. Sleep, disable toggling and latched-fault phases interleave, so the bench observes a fault that survives a sleep period and is then released by each disable input in turn.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NUM_LEGS = 2;

  // bit positions of the synchronized control vector
  localparam int IDX_SHORT = 0;
  localparam int IDX_OT    = 1;
  localparam int IDX_UV    = 2;
  localparam int IDX_POL0  = 3;
  localparam int IDX_POL1  = 4;
  localparam int IDX_DISLN = 5;
  localparam int IDX_DISH  = 6;
  localparam int IDX_EN    = 7;
  localparam int CTRL_W    = 8;

  typedef enum logic [1:0] {
    LEG_FLOAT = 2'd0,
    LEG_HIGH  = 2'd1,
    LEG_LOW   = 2'd2
  } legState_e;

  // strobes from the supervisory control to the leg datapath
  typedef struct packed {
    logic [NUM_LEGS-1:0] legOn;
    logic [NUM_LEGS-1:0] legHigh;
  } legStrobe_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0] <= d;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/hb_control.sv
module hb_control
  import hb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sEn,
  input  logic                sDisHi,
  input  logic                sDisLoN,
  input  logic [NUM_LEGS-1:0] sPol,
  input  logic                sUv,
  input  logic                sOt,
  input  logic                sShort,
  output legStrobe_t          strobe,
  output logic                latched,
  output logic                faultN
);
  logic disabled;
  logic hardFault;
  logic driveOk;
  logic latchNext;
  logic faultNext;

  always_comb begin
    disabled  = sDisHi | ~sDisLoN;
    hardFault = sOt | sShort;
    // a disabling level wipes the latch; it re-arms once released
    latchNext = disabled ? 1'b0 : (latched | (sEn & hardFault));
    driveOk   = sEn & ~disabled & ~sUv & ~latched & ~hardFault;
    if (!sEn) faultNext = 1'b1;
    else      faultNext = ~(disabled | sUv | latched | hardFault);
    strobe.legOn   = {NUM_LEGS{driveOk}};
    strobe.legHigh = sPol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latched <= 1'b0;
      faultN  <= 1'b1;
    end else begin
      latched <= latchNext;
      faultN  <= faultNext;
    end
  end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEAD_W-1:0] deadTime,
  input  logic              reqOn,
  input  logic              reqHigh,
  output logic              gateHi,
  output logic              gateLo
);
  localparam logic [DEAD_W-1:0] CNT_MAX = {DEAD_W{1'b1}};
  localparam logic [DEAD_W-1:0] CNT_ONE = DEAD_W'(1);

  legState_e         state, stateNext;
  logic [DEAD_W-1:0] offCnt, offCntNext;
  legState_e         target;
  logic [DEAD_W-1:0] offCntInc;

  always_comb begin
    target     = reqHigh ? LEG_HIGH : LEG_LOW;
    offCntInc  = (offCnt == CNT_MAX) ? offCnt : offCnt + CNT_ONE;
    stateNext  = state;
    offCntNext = offCnt;
    if (!reqOn) begin
      if (state != LEG_FLOAT) begin
        stateNext  = LEG_FLOAT;
        offCntNext = CNT_ONE;
      end else begin
        offCntNext = offCntInc;
      end
    end else if (state == target) begin
      stateNext = state;
    end else if (state != LEG_FLOAT) begin
      stateNext  = LEG_FLOAT;
      offCntNext = CNT_ONE;
    end else if (offCnt >= deadTime) begin
      stateNext = target;
    end else begin
      offCntNext = offCntInc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= LEG_FLOAT;
      offCnt <= CNT_MAX;
    end else begin
      state  <= stateNext;
      offCnt <= offCntNext;
    end
  end

  assign gateHi = (state == LEG_HIGH);
  assign gateLo = (state == LEG_LOW);
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_W     = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DEAD_W-1:0]   deadTime,
  input  logic                enIn,
  input  logic                disHiIn,
  input  logic                disLoNIn,
  input  logic [NUM_LEGS-1:0] polIn,
  input  logic                uvFlag,
  input  logic                otFlag,
  input  logic                shortFlag,
  output logic [NUM_LEGS-1:0] gateHi,
  output logic [NUM_LEGS-1:0] gateLo,
  output logic                faultN
);
  logic [CTRL_W-1:0] rawCtrl;
  logic [CTRL_W-1:0] syncCtrl;
  legStrobe_t        strobe;
  logic              latched;
  logic              syncEn;
  logic              syncDis;
  logic              syncUv;

  assign rawCtrl = {enIn, disHiIn, disLoNIn, polIn[1], polIn[0], uvFlag, otFlag, shortFlag};

  hb_sync #(.WIDTH(CTRL_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (rawCtrl),
    .q   (syncCtrl)
  );

  assign syncEn  = syncCtrl[IDX_EN];
  assign syncDis = syncCtrl[IDX_DISH] | ~syncCtrl[IDX_DISLN];
  assign syncUv  = syncCtrl[IDX_UV];

  hb_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sEn    (syncCtrl[IDX_EN]),
    .sDisHi (syncCtrl[IDX_DISH]),
    .sDisLoN(syncCtrl[IDX_DISLN]),
    .sPol   ({syncCtrl[IDX_POL1], syncCtrl[IDX_POL0]}),
    .sUv    (syncCtrl[IDX_UV]),
    .sOt    (syncCtrl[IDX_OT]),
    .sShort (syncCtrl[IDX_SHORT]),
    .strobe (strobe),
    .latched(latched),
    .faultN (faultN)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hb_leg #(.DEAD_W(DEAD_W)) u_leg (
      .clk     (clk),
      .rstN    (rstN),
      .deadTime(deadTime),
      .reqOn   (strobe.legOn[g]),
      .reqHigh (strobe.legHigh[g]),
      .gateHi  (gateHi[g]),
      .gateLo  (gateLo[g])
    );
  end
endmodule

// File: rtl/hb_checker.sv
module hb_checker
  import hb_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                syncEn,
  input logic                syncDis,
  input logic                syncUv,
  input logic                latched,
  input logic [NUM_LEGS-1:0] gateHi,
  input logic [NUM_LEGS-1:0] gateLo,
  input logic                faultN
);
  p_sleep_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> (faultN && gateHi == '0 && gateLo == '0));

  p_disable_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (syncEn && syncDis) |=> (!faultN && gateHi == '0 && gateLo == '0));

  p_uv_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (syncEn && syncUv) |=> (!faultN && gateHi == '0 && gateLo == '0));

  p_latch_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    latched |=> (gateHi == '0 && gateLo == '0));

  p_latch_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latched) |-> $past(syncDis));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi & gateLo) == '0);

  p_gap_leg0_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateHi[0]) || $rose(gateLo[0])) |-> $past(!gateHi[0] && !gateLo[0]));

  p_gap_leg1_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateHi[1]) || $rose(gateLo[1])) |-> $past(!gateHi[1] && !gateLo[1]));
endmodule

bind hbridge_ctrl hb_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .syncEn (syncEn),
  .syncDis(syncDis),
  .syncUv (syncUv),
  .latched(latched),
  .gateHi (gateHi),
  .gateLo (gateLo),
  .faultN (faultN)
);

// File: tb/hbridge_ctrl_tb.sv
`timescale 1ns/1ps
module hbridge_ctrl_tb;
  localparam int DW    = 3;
  localparam int SD    = 2;
  localparam int CMAX  = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] deadTime = 3'd3;
  logic          enIn = 1'b0, disHiIn = 1'b0, disLoNIn = 1'b1;
  logic [1:0]    polIn = 2'b00;
  logic          uvFlag = 1'b0, otFlag = 1'b0, shortFlag = 1'b0;
  logic [1:0]    gateHi, gateLo;
  logic          faultN;

  int vectors = 0;
  int errors  = 0;
  string phaseTag = "R10";

  // reference model state
  logic [7:0] hist[$];
  int  mState[2];   // 0 float, 1 high, 2 low
  int  mCnt[2];
  bit  mLatch;
  bit  mFault;

  always #2.5 clk = ~clk;

  hbridge_ctrl #(.DEAD_W(DW), .SYNC_DEPTH(SD)) u_dut (
    .clk(clk), .rstN(rstN), .deadTime(deadTime), .enIn(enIn), .disHiIn(disHiIn),
    .disLoNIn(disLoNIn), .polIn(polIn), .uvFlag(uvFlag), .otFlag(otFlag),
    .shortFlag(shortFlag), .gateHi(gateHi), .gateLo(gateLo), .faultN(faultN)
  );

  task automatic modelReset();
    hist.delete();
    for (int k = 0; k < SD; k++) hist.push_back(8'h00);
    for (int i = 0; i < 2; i++) begin mState[i] = 0; mCnt[i] = CMAX; end
    mLatch = 0;
    mFault = 1;
  endtask

  task automatic modelEdge();
    logic [7:0] v;
    bit en, dis, uv, hard, ok, nextLatch;
    if (!rstN) begin modelReset(); return; end
    hist.push_back({enIn, disHiIn, disLoNIn, polIn[1], polIn[0], uvFlag, otFlag, shortFlag});
    v    = hist.pop_front();
    en   = v[7];
    dis  = v[6] || !v[5];
    uv   = v[2];
    hard = v[1] || v[0];
    ok   = en && !dis && !uv && !mLatch && !hard;
    mFault    = !en ? 1'b1 : !(dis || uv || mLatch || hard);
    nextLatch = dis ? 1'b0 : (mLatch || (en && hard));
    for (int i = 0; i < 2; i++) begin
      int want;
      want = !ok ? 0 : (v[3+i] ? 1 : 2);
      if (want == 0) begin
        if (mState[i] != 0) begin mState[i] = 0; mCnt[i] = 1; end
        else if (mCnt[i] < CMAX) mCnt[i]++;
      end else if (mState[i] != want) begin
        if (mState[i] != 0) begin mState[i] = 0; mCnt[i] = 1; end
        else if (mCnt[i] >= int'(deadTime)) mState[i] = want;
        else if (mCnt[i] < CMAX) mCnt[i]++;
      end
    end
    mLatch = nextLatch;
  endtask

  task automatic compare();
    logic [1:0] eHi, eLo;
    for (int i = 0; i < 2; i++) begin
      eHi[i] = (mState[i] == 1);
      eLo[i] = (mState[i] == 2);
    end
    vectors++;
    if (gateHi !== eHi || gateLo !== eLo || faultN !== mFault) begin
      errors++;
      $display("FAIL %s t=%0t hi=%b lo=%b fN=%b expected hi=%b lo=%b fN=%b",
               phaseTag, $time, gateHi, gateLo, faultN, eHi, eLo, mFault);
    end
    vectors++;
    if ((gateHi & gateLo) !== 2'b00) begin
      errors++;
      $display("FAIL R8 overlap hi=%b lo=%b expected no common bit", gateHi, gateLo);
    end
  endtask

  task automatic step(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      modelEdge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic expectBits(input string tag, input logic [4:0] act, input logic [4:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {hi,lo,fN} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired, expected run to finish");
    finishRun();
  end

  initial begin
    modelReset();
    @(negedge clk);
    step(4);
    rstN = 1'b1;
    phaseTag = "R10";
    step(1);
    expectBits("R10", {gateHi, gateLo, faultN}, 5'b0000_1);

    phaseTag = "R4";
    disHiIn = 1; otFlag = 1; polIn = 2'b01; step(3);
    disHiIn = 0; disLoNIn = 0; uvFlag = 1; step(3);
    disLoNIn = 1; uvFlag = 0; otFlag = 0; shortFlag = 1; step(3);
    shortFlag = 0; step(3);
    expectBits("R4", {gateHi, gateLo, faultN}, 5'b0000_1);

    // R9: enable with forward polarity; gates move on the third edge
    phaseTag = "R9";
    enIn = 1; polIn = 2'b01;
    step(2);
    expectBits("R9", {gateHi, gateLo, faultN}, 5'b0000_1);
    step(1);
    expectBits("R9", {gateHi, gateLo, faultN}, 5'b01_10_1);

    phaseTag = "R1"; step(5);
    // R8: reverse with deadTime 3
    phaseTag = "R8";
    polIn = 2'b10;
    step(3);
    expectBits("R8", {gateHi, gateLo, faultN}, 5'b00_00_1);
    step(2);
    expectBits("R8", {gateHi, gateLo, faultN}, 5'b00_00_1);
    step(1);
    expectBits("R8", {gateHi, gateLo, faultN}, 5'b10_01_1);
    step(4);
    phaseTag = "R1"; expectBits("R1", {gateHi, gateLo, faultN}, 5'b10_01_1);

    phaseTag = "R2";
    polIn = 2'b11; step(12);
    expectBits("R2", {gateHi, gateLo, faultN}, 5'b11_00_1);
    polIn = 2'b00; step(12);
    expectBits("R2", {gateHi, gateLo, faultN}, 5'b00_11_1);

    phaseTag = "R8";
    deadTime = 3'd0; polIn = 2'b01; step(8);
    deadTime = 3'd7; polIn = 2'b10; step(16);
    deadTime = 3'd1; polIn = 2'b01; step(8);

    phaseTag = "R3";
    disHiIn = 1; step(5);
    expectBits("R3", {gateHi, gateLo, faultN}, 5'b00_00_0);
    disHiIn = 0; step(8);
    disLoNIn = 0; step(5);
    expectBits("R3", {gateHi, gateLo, faultN}, 5'b00_00_0);
    disLoNIn = 1; step(8);

    phaseTag = "R5";
    uvFlag = 1; step(5);
    expectBits("R5", {gateHi, gateLo, faultN}, 5'b00_00_0);
    uvFlag = 0; step(8);
    expectBits("R5", {gateHi, gateLo, faultN}, 5'b01_10_1);

    phaseTag = "R6";
    otFlag = 1; step(4);
    otFlag = 0; step(8);
    expectBits("R6", {gateHi, gateLo, faultN}, 5'b00_00_0);
    enIn = 0; step(5);
    expectBits("R6", {gateHi, gateLo, faultN}, 5'b00_00_1);
    enIn = 1; step(6);
    phaseTag = "R7";
    expectBits("R7", {gateHi, gateLo, faultN}, 5'b00_00_0);
    disLoNIn = 0; step(2);
    disLoNIn = 1; step(10);
    expectBits("R7", {gateHi, gateLo, faultN}, 5'b01_10_1);
    shortFlag = 1; step(1);
    shortFlag = 0; step(8);
    expectBits("R7", {gateHi, gateLo, faultN}, 5'b00_00_0);
    disHiIn = 1; step(1);
    disHiIn = 0; step(10);
    expectBits("R7", {gateHi, gateLo, faultN}, 5'b01_10_1);

    phaseTag = "R1";
    for (int n = 0; n < 400; n++) begin
      enIn      = ($urandom % 8) != 0;
      disHiIn   = ($urandom % 7) == 0;
      disLoNIn  = ($urandom % 7) != 0;
      polIn     = 2'($urandom);
      uvFlag    = ($urandom % 10) == 0;
      otFlag    = ($urandom % 30) == 0;
      shortFlag = ($urandom % 30) == 0;
      if (($urandom % 20) == 0) deadTime = 3'($urandom);
      step(1 + int'($urandom % 6));
    end

    phaseTag = "R10";
    rstN = 0; step(2);
    expectBits("R10", {gateHi, gateLo, faultN}, 5'b00_00_1);
    finishRun();
  end
endmodule